// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The line first passes through a two-flop synchronizer. A tick generator divides the core clock by a 16-bit divisor to make an oversampling tick, and every bit period lasts sixteen of these ticks. A small state machine finds the start of a frame and checks that the start bit is real. It then takes three samples near the centre of each bit and lets a two-out-of-three vote decide the bit value. The voted bits are packed into a byte, least significant bit first. When the stop bit is good, the byte appears on the output with a single-cycle valid strobe, ready to be written into a receive FIFO.

A frame is one low start bit, eight data bits, no parity and one or more high stop bits. The idle line is high. Reception runs only while the enable input is high. Clearing the enable sends the machine back to idle, and a frame that was being received is lost.

The state machine has four states. IDLE waits for a falling edge, meaning a tick that sees the line low after an earlier tick saw it high. IDLE→START is taken on that edge. START→IDLE is the abandon path, taken when the voted start bit is high. START→DATA is taken at the end of the start bit period. DATA→STOP is taken at the end of the eighth data bit. STOP→IDLE is taken at the vote of the stop bit: the byte is delivered if the vote is high and dropped if it is low. Any state goes to IDLE whenever the enable is low.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset, rx_valid is 0 and rx_data is 0x00.
- R2: While rx_en is high and divisor is held constant, the internal oversample tick fires once every divisor+1 clock cycles. A divisor of 0 gives a tick on every cycle.
- R3: A frame starts only on a falling edge seen on the ticks. A line that is already low when reception is enabled, or after reset, does not start a frame until it has been seen high.
- R4: The start bit is voted at oversample ticks 7, 8 and 9 after the edge tick (tick 0). If the vote is high, the frame is abandoned with no strobe and the receiver returns to IDLE.
- R5: Each data bit and the stop bit are decided by a 2-of-3 majority of the samples at ticks 7, 8 and 9 of that bit. A disturbance that changes only one of the three samples does not change the result.
- R6: The eight data bits are assembled least significant bit first. The byte is presented on rx_data together with rx_valid high for exactly one clock cycle.
- R7: If the voted stop bit is low, the byte is discarded and no strobe is issued. No new frame starts until the line has been seen high again.
- R8: While rx_en is low, the state returns to IDLE and rx_valid stays 0, whatever the line does.
- R9: Frames are received correctly for divisor values 0, 1, 2 and 5.
- R10: Back-to-back frames with a single stop bit are each received, with no byte lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low holds the receiver idle |
| divisor | input | 16 | Oversample tick period minus one, in clock cycles |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte on rx_data |

## Verification
Every byte value from 0x00 to 0xFF is sent back to back at a divisor of 1. This shows that bit order, assembly and single-stop-bit framing work for every data pattern. Shorter sweeps at divisors 0, 2 and 5 show that the bit timing follows the divisor. Two-cycle inverted pulses, placed at several offsets around a bit centre, can disturb at most one vote sample, so they tell the majority vote apart from a single-sample decision. Four further patterns are each checked for the absence of a strobe: a short low pulse (false start), a frame with a low stop bit, a frame sent while disabled, and a line held low across enable. A low pulse that is followed by rising activity would show a spurious byte if the edge rule, the abandon path or the enable gating were wrong.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Resets to the idle (high) line level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/ovs_rx_tick.sv
module ovs_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (!enable)          count <= '0;
        else if (count == divisor) count <= '0;
        else                       count <= count + 1'b1;
    end

    assign tick = enable && (count == divisor);
endmodule

// File: rtl/ovs_rx_vote.sv
module ovs_rx_vote #(
    parameter int OSR   = 16,
    parameter int FIRST = 7,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [PH_W-1:0] phase,
    input  logic            line,
    output logic            maj
);
    logic samp_a, samp_b;

    // Hold the first two samples; the third is the live line at FIRST+2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (phase == PH_W'(FIRST))     samp_a <= line;
            if (phase == PH_W'(FIRST + 1)) samp_b <= line;
        end
    end

    assign maj = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic [DIV_W-1:0]     divisor,
    input  logic                 serial_in,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid
);
    import ovs_rx_pkg::*;

    localparam int PH_W       = $clog2(OSR);
    localparam int CNT_W      = $clog2(DATA_BITS);
    localparam int SAMP_FIRST = OSR / 2 - 1;
    localparam int VOTE_PH    = SAMP_FIRST + 2;

    rx_state_e             state, nstate;
    logic [PH_W-1:0]       ph;
    logic [CNT_W-1:0]      bitcnt;
    logic [DATA_BITS-1:0]  shreg;
    logic                  last_hi;
    logic                  line_s;
    logic                  tick;
    logic                  maj;
    logic                  decide;
    logic                  bit_end;

    ovs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (serial_in),
        .q_out (line_s)
    );

    ovs_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (rx_en),
        .divisor (divisor),
        .tick    (tick)
    );

    ovs_rx_vote #(.OSR(OSR), .FIRST(SAMP_FIRST)) u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .phase (ph),
        .line  (line_s),
        .maj   (maj)
    );

    assign decide  = tick && (ph == PH_W'(VOTE_PH));
    assign bit_end = tick && (ph == PH_W'(OSR - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (!rx_en) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (tick && last_hi && !line_s) nstate = ST_START;
                ST_START: begin
                    if (decide && maj)  nstate = ST_IDLE;
                    else if (bit_end)   nstate = ST_DATA;
                end
                ST_DATA:  if (bit_end && bitcnt == CNT_W'(DATA_BITS - 1)) nstate = ST_STOP;
                ST_STOP:  if (decide) nstate = ST_IDLE;
            endcase
        end
    end

    // Bit timing, bit counter, shift register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= PH_W'(1);
            bitcnt  <= '0;
            shreg   <= '0;
            last_hi <= 1'b0;
        end else begin
            if (!rx_en || state == ST_IDLE) ph <= PH_W'(1);
            else if (tick)                  ph <= ph + 1'b1;

            if (state != ST_DATA) bitcnt <= '0;
            else if (bit_end)     bitcnt <= bitcnt + 1'b1;

            if (state == ST_DATA && decide) shreg <= {maj, shreg[DATA_BITS-1:1]};

            if (!rx_en)    last_hi <= 1'b0;
            else if (tick) last_hi <= line_s;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= rx_en && state == ST_STOP && decide && maj;
            if (rx_en && state == ST_STOP && decide && maj) rx_data <= shreg;
        end
    end
endmodule

// File: rtl/ovs_rx_chk.sv
module ovs_rx_chk #(
    parameter int OSR   = 16,
    parameter int DIV_W = 16,
    localparam int PH_W = $clog2(OSR)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_en,
    input logic [DIV_W-1:0]       divisor,
    input logic                   rx_valid,
    input logic                   tick,
    input logic                   maj,
    input logic [PH_W-1:0]        ph,
    input ovs_rx_pkg::rx_state_e  state
);
    import ovs_rx_pkg::*;

    localparam int VOTE_PH = OSR / 2 + 1;

    logic [DIV_W:0] gap;
    logic           seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (!rx_en) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && tick && seen) |-> (gap == {1'b0, divisor}));

    assert_start_abandon_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && state == ST_START && tick && ph == PH_W'(VOTE_PH) && maj) |=> (state == ST_IDLE));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_bad_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && tick && ph == PH_W'(VOTE_PH) && !maj) |=> !rx_valid);

    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_valid && state == ST_IDLE));
endmodule

bind ovs_uart_rx ovs_rx_chk #(.OSR(OSR), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .divisor  (divisor),
    .rx_valid (rx_valid),
    .tick     (tick),
    .maj      (maj),
    .ph       (ph),
    .state    (state)
);

// File: tb/ovs_uart_rx_bench.sv
`timescale 1ns/1ps
module ovs_uart_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic        serial_in = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid;

    int checks = 0;
    int fails  = 0;
    int exp_wr = 0;
    int got_rd = 0;
    int cycles = 0;
    logic [7:0] exp_q [0:1023];

    always #2.5 clk = ~clk;

    ovs_uart_rx u_ovs_uart_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .divisor   (divisor),
        .serial_in (serial_in),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Strobe monitor: R6 byte value against the expected stream (R9, R10)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (got_rd >= exp_wr) begin
                check(1'b0, "R6 unexpected strobe", rx_data, 0);
            end else begin
                check(rx_data == exp_q[got_rd], "R6 byte", rx_data, exp_q[got_rd]);
            end
            got_rd++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            check(1'b0, "watchdog", cycles, 195000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic hold(input logic v, input int n);
        serial_in = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One frame; gbit selects a data bit to disturb with a 2-cycle inverted pulse
    task automatic send_frame(input logic [7:0] b, input bit stop_ok, input int gbit, input int goff);
        int p;
        p = 16 * (int'(divisor) + 1);
        if (stop_ok) begin
            exp_q[exp_wr] = b;
            exp_wr++;
        end
        hold(1'b0, p);
        for (int i = 0; i < 8; i++) begin
            if (i == gbit) begin
                hold(b[i], p / 2 + goff);
                hold(!b[i], 2);
                hold(b[i], p - p / 2 - goff - 2);
            end else begin
                hold(b[i], p);
            end
        end
        if (stop_ok) hold(1'b1, p);
        else begin
            hold(1'b0, p);
            hold(1'b1, 2 * p);
        end
    endtask

    task automatic set_div(input int d);
        rx_en = 1'b0;
        @(posedge clk); #1;
        divisor = 16'(d);
        rx_en = 1'b1;
        hold(1'b1, 40 * (d + 1));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
        check(rx_data == 8'h00, "R1 data after reset", rx_data, 0);

        // R10 / R6: every byte back to back at divisor 1
        set_div(1);
        for (int v = 0; v < 256; v++) send_frame(8'(v), 1'b1, -1, 0);
        hold(1'b1, 64);
        check(got_rd == exp_wr, "R10 count full sweep", got_rd, exp_wr);

        // R5: single-sample disturbances around the bit centre
        for (int k = 0; k < 6; k++) begin
            send_frame(8'h5A ^ 8'(k * 37), 1'b1, k % 8, k - 3);
            send_frame(8'hC3 ^ 8'(k * 11), 1'b1, (k + 3) % 8, k - 3);
        end
        hold(1'b1, 64);
        check(got_rd == exp_wr, "R5 count disturbed", got_rd, exp_wr);

        // R4: short low pulse is a false start
        hold(1'b0, 6);
        hold(1'b1, 96);
        check(got_rd == exp_wr, "R4 false start", got_rd, exp_wr);
        send_frame(8'hA5, 1'b1, -1, 0);
        hold(1'b1, 32);
        check(got_rd == exp_wr, "R4 recovery", got_rd, exp_wr);

        // R7: low stop bit drops the byte; next frame still received
        send_frame(8'h3C, 1'b0, -1, 0);
        check(got_rd == exp_wr, "R7 bad stop", got_rd, exp_wr);
        send_frame(8'h81, 1'b1, -1, 0);
        hold(1'b1, 32);
        check(got_rd == exp_wr, "R7 recovery", got_rd, exp_wr);

        // R8: frame while disabled
        rx_en = 1'b0;
        send_frame(8'h77, 1'b0, -1, 0);
        hold(1'b1, 64);
        check(got_rd == exp_wr, "R8 disabled", got_rd, exp_wr);

        // R3: line low across enable, then high with activity
        serial_in = 1'b0;
        hold(1'b0, 16);
        rx_en = 1'b1;
        hold(1'b0, 40);
        hold(1'b1, 12 * 32);
        check(got_rd == exp_wr, "R3 low at enable", got_rd, exp_wr);
        send_frame(8'h42, 1'b1, -1, 0);
        hold(1'b1, 32);
        check(got_rd == exp_wr, "R3 recovery", got_rd, exp_wr);

        // R9: other divisors
        set_div(0);
        for (int v = 0; v < 64; v++) send_frame(8'(v * 5 + 3), 1'b1, -1, 0);
        hold(1'b1, 32);
        check(got_rd == exp_wr, "R9 divisor 0", got_rd, exp_wr);
        set_div(2);
        for (int v = 0; v < 16; v++) send_frame(8'(v * 17 + 1), 1'b1, -1, 0);
        hold(1'b1, 96);
        check(got_rd == exp_wr, "R9 divisor 2", got_rd, exp_wr);
        set_div(5);
        for (int v = 0; v < 8; v++) send_frame(8'(v * 29 + 8), 1'b1, -1, 0);
        hold(1'b1, 192);
        check(got_rd == exp_wr, "R9 divisor 5", got_rd, exp_wr);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule